// File: doc/BRIEF.md
# Configurable GPIO Register Bank

This block is the general-purpose I/O bank of a small 8-bit controller. It holds three bidirectional ports of eight, four and eight pins and one output-only port of eight pins. Software reaches every register through a plain synchronous register bus. Each bidirectional port has three byte addresses: a drive-value register, a direction register and a read-only view of the synchronized pin levels. For every pin, the pair {direction bit, drive-value bit} picks one of four states: floating input, input with weak pull-up, driven low, or driven high. The bank turns that choice into per-pin output-enable, output-value and pull-up-enable signals for the pad ring.

The top two pins of the eight-pin G port can only be inputs. Their direction bits cannot be set. Bit 7 of the G drive-value register doubles as a halt request. Software sets it, and it stays set until the wake input or reset clears it. Nothing here streams, so the bus has no valid/ready handshake. A write takes effect on the clock edge that samples the strobe. A read returns data on the edge after the address is presented, with no back-pressure.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every L, C and G drive-value and direction register reads zero. All output-enable and pull-up outputs are low and halt_req is low.
- R2: For each L, C and G pin, the outputs follow the register bits. With direction=0 and value=0, oe, out and pu are all 0. With direction=0 and value=1, pu=1 and oe=0. With direction=1, oe=1, out equals the value bit and pu=0. The out bit is 0 whenever the direction bit is 0.
- R3: Address map: L value 0x0, L direction 0x1, L pins 0x2; G value 0x4, G direction 0x5, G pins 0x6; C value 0x8, C direction 0x9, C pins 0xA; D value 0xC. rdata shows the addressed register on the clock edge after the address is presented.
- R4: A pin-view address returns the external pin levels after a two-stage synchronizer. A level held for four clocks is readable.
- R5: G direction bits 7 and 6 ignore writes, always read zero and never enable their outputs. Their pin levels still appear at address 0x6.
- R6: Port C is 4 bits wide. Bits 7..4 read zero at 0x8, 0x9 and 0xA, whatever is written there.
- R7: D is an 8-bit output-only port. d_out is all ones while reset is asserted, and it stays all ones after reset until the first write. Written values appear on d_out and read back at 0xC.
- R8: Writing G value with bit 7 = 1 raises halt_req on the next edge. halt_req stays high until wake is sampled high or reset occurs. Wake clears only bit 7 of the G value register.
- R9: When a G value write and wake fall in the same cycle, the written bit 7 wins.
- R10: Unmapped addresses (0x3, 0x7, 0xB, 0xD to 0xF) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Read data, one cycle after addr |
| l_pin | input | 8 | L port pad levels |
| l_oe | output | 8 | L output enables |
| l_out | output | 8 | L output values |
| l_pu | output | 8 | L pull-up enables |
| c_pin | input | 4 | C port pad levels |
| c_oe | output | 4 | C output enables |
| c_out | output | 4 | C output values |
| c_pu | output | 4 | C pull-up enables |
| g_pin | input | 8 | G port pad levels |
| g_oe | output | 8 | G output enables |
| g_out | output | 8 | G output values |
| g_pu | output | 8 | G pull-up enables |
| d_out | output | 8 | D port output levels |
| wake | input | 1 | Clears the halt bit |
| halt_req | output | 1 | Halt request level |

## Verification
The wake input and a software write to the G value register can land in the same cycle, and both target bit 7. The bench raises wake and the write strobe on the same falling edge, once with written bit 7 set and once with it clear. It then judges halt_req and the G value readback after the next rising edge: the written value must survive in both cases. A separate case pulses wake alone, to show that the other bits of the register are kept.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W    = 8;
  localparam int L_W      = 8;
  localparam int C_W      = 4;
  localparam int G_W      = 8;
  localparam int D_W      = 8;
  localparam int HALT_BIT = 7;

  localparam int A_L_VAL = 'h0;
  localparam int A_L_DIR = 'h1;
  localparam int A_L_PIN = 'h2;
  localparam int A_G_VAL = 'h4;
  localparam int A_G_DIR = 'h5;
  localparam int A_G_PIN = 'h6;
  localparam int A_C_VAL = 'h8;
  localparam int A_C_DIR = 'h9;
  localparam int A_C_PIN = 'hA;
  localparam int A_D_VAL = 'hC;

  localparam logic [G_W-1:0] G_IN_ONLY = 8'hC0;

  function automatic logic is_mapped(input int a);
    return (a == A_L_VAL) || (a == A_L_DIR) || (a == A_L_PIN) ||
           (a == A_G_VAL) || (a == A_G_DIR) || (a == A_G_PIN) ||
           (a == A_C_VAL) || (a == A_C_DIR) || (a == A_C_PIN) ||
           (a == A_D_VAL);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode (
  input  logic dir,
  input  logic val,
  output logic oe,
  output logic out,
  output logic pu
);
  always_comb begin
    oe  = dir;
    out = dir & val;
    pu  = ~dir & val;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int              W           = 8,
  parameter int              ADDR_W      = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_VAL     = '0,
  parameter logic [ADDR_W-1:0] A_DIR     = '0,
  parameter logic [ADDR_W-1:0] A_PIN     = '0,
  parameter logic [W-1:0]    IN_ONLY     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [W-1:0]      clr,
  input  logic [W-1:0]      pin,
  output logic [W-1:0]      oe,
  output logic [W-1:0]      out,
  output logic [W-1:0]      pu,
  output logic [W-1:0]      val_q,
  output logic [7:0]        rd_val
);
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= '0;
    end else begin
      if (we && addr == A_VAL) val_q <= wdata[W-1:0];
      else                     val_q <= val_q & ~clr;
      if (we && addr == A_DIR) dir_q <= wdata[W-1:0] & ~IN_ONLY;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_mode i_mode (
      .dir(dir_q[i]), .val(val_q[i]),
      .oe(oe[i]), .out(out[i]), .pu(pu[i])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr == A_VAL)      rd_val[W-1:0] = val_q;
    else if (addr == A_DIR) rd_val[W-1:0] = dir_q;
    else if (addr == A_PIN) rd_val[W-1:0] = pin_s;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  input  logic [L_W-1:0]    l_pin,
  output logic [L_W-1:0]    l_oe,
  output logic [L_W-1:0]    l_out,
  output logic [L_W-1:0]    l_pu,
  input  logic [C_W-1:0]    c_pin,
  output logic [C_W-1:0]    c_oe,
  output logic [C_W-1:0]    c_out,
  output logic [C_W-1:0]    c_pu,
  input  logic [G_W-1:0]    g_pin,
  output logic [G_W-1:0]    g_oe,
  output logic [G_W-1:0]    g_out,
  output logic [G_W-1:0]    g_pu,
  output logic [D_W-1:0]    d_out,
  input  logic              wake,
  output logic              halt_req
);
  localparam logic [ADDR_W-1:0] AD_D = ADDR_W'(A_D_VAL);

  logic [7:0]     l_rd, c_rd, g_rd, d_rd, rd_next;
  logic [L_W-1:0] l_val;
  logic [C_W-1:0] c_val;
  logic [G_W-1:0] g_val, g_clr;
  logic [D_W-1:0] d_q;

  always_comb begin
    g_clr           = '0;
    g_clr[HALT_BIT] = wake;
  end

  gpio_port #(
    .W(L_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .A_VAL(ADDR_W'(A_L_VAL)), .A_DIR(ADDR_W'(A_L_DIR)), .A_PIN(ADDR_W'(A_L_PIN)),
    .IN_ONLY('0)
  ) i_port_l (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .clr('0), .pin(l_pin), .oe(l_oe), .out(l_out), .pu(l_pu),
    .val_q(l_val), .rd_val(l_rd)
  );

  gpio_port #(
    .W(C_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .A_VAL(ADDR_W'(A_C_VAL)), .A_DIR(ADDR_W'(A_C_DIR)), .A_PIN(ADDR_W'(A_C_PIN)),
    .IN_ONLY('0)
  ) i_port_c (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .clr('0), .pin(c_pin), .oe(c_oe), .out(c_out), .pu(c_pu),
    .val_q(c_val), .rd_val(c_rd)
  );

  gpio_port #(
    .W(G_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .A_VAL(ADDR_W'(A_G_VAL)), .A_DIR(ADDR_W'(A_G_DIR)), .A_PIN(ADDR_W'(A_G_PIN)),
    .IN_ONLY(G_IN_ONLY)
  ) i_port_g (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .clr(g_clr), .pin(g_pin), .oe(g_oe), .out(g_out), .pu(g_pu),
    .val_q(g_val), .rd_val(g_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 d_q <= '1;
    else if (we && addr == AD_D) d_q <= wdata[D_W-1:0];
  end

  always_comb begin
    d_rd = '0;
    if (addr == AD_D) d_rd[D_W-1:0] = d_q;
    rd_next = l_rd | c_rd | g_rd | d_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

  assign d_out    = rst_n ? d_q : '1;
  assign halt_req = g_val[HALT_BIT];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              we,
  input logic [7:0]        rdata,
  input logic [L_W-1:0]    l_oe,
  input logic [G_W-1:0]    g_oe,
  input logic [D_W-1:0]    d_out,
  input logic              wake,
  input logic              halt_req
);
  logic g_val_wr;
  assign g_val_wr = we && (int'(addr) == A_G_VAL);

  assert_ldir_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == A_L_DIR) |=> (l_oe == $past(wdata[L_W-1:0])));

  assert_g_input_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == A_G_DIR) |=> (g_oe[7:6] == 2'b00));

  assert_dreset_ones_R7: assert property (@(posedge clk)
    (!rst_n) |-> (d_out == '1));

  assert_halt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (g_val_wr && wdata[HALT_BIT]) |=> halt_req);

  assert_wake_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !g_val_wr) |=> !halt_req);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mapped(int'(addr))) |=> (rdata == 8'h00));
endmodule

bind gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .rdata(rdata), .l_oe(l_oe), .g_oe(g_oe), .d_out(d_out),
  .wake(wake), .halt_req(halt_req)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [7:0] l_pin = '0, l_oe, l_out, l_pu;
  logic [3:0] c_pin = '0, c_oe, c_out, c_pu;
  logic [7:0] g_pin = '0, g_oe, g_out, g_pu;
  logic [7:0] d_out;
  logic       wake = 1'b0;
  logic       halt_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .l_pin(l_pin), .l_oe(l_oe), .l_out(l_out), .l_pu(l_pu),
    .c_pin(c_pin), .c_oe(c_oe), .c_out(c_out), .c_pu(c_pu),
    .g_pin(g_pin), .g_oe(g_oe), .g_out(g_out), .g_pu(g_pu),
    .d_out(d_out), .wake(wake), .halt_req(halt_req)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check({7'b0, halt_req}, 8'h00, "R1", "halt after reset");
    check(l_oe | l_pu, 8'h00, "R1", "L oe/pu after reset");
    check(g_oe | g_pu, 8'h00, "R1", "G oe/pu after reset");
    check({4'b0, c_oe | c_pu}, 8'h00, "R1", "C oe/pu after reset");
    rd(4'h1, v); check(v, 8'h00, "R1", "L dir reset");
    rd(4'h4, v); check(v, 8'h00, "R1", "G val reset");
    check(d_out, 8'hFF, "R7", "D after reset");
    rd(4'hC, v); check(v, 8'hFF, "R7", "D readback after reset");
  endtask

  task automatic t_modes;
    wr(4'h1, 8'hCC); wr(4'h0, 8'hAA);
    check(l_oe, 8'hCC, "R2", "L oe pattern1");
    check(l_out, 8'h88, "R2", "L out pattern1");
    check(l_pu, 8'h22, "R2", "L pu pattern1");
    wr(4'h1, 8'h0F); wr(4'h0, 8'h3C);
    check(l_oe, 8'h0F, "R2", "L oe pattern2");
    check(l_out, 8'h0C, "R2", "L out pattern2");
    check(l_pu, 8'h30, "R2", "L pu pattern2");
  endtask

  task automatic t_readback;
    logic [7:0] v;
    rd(4'h0, v); check(v, 8'h3C, "R3", "L val readback");
    rd(4'h1, v); check(v, 8'h0F, "R3", "L dir readback");
    wr(4'h9, 8'h05);
    rd(4'h9, v); check(v, 8'h05, "R3", "C dir readback");
  endtask

  task automatic t_pins;
    logic [7:0] v;
    @(negedge clk);
    l_pin = 8'h5A; g_pin = 8'hC3; c_pin = 4'hA;
    repeat (4) @(negedge clk);
    rd(4'h2, v); check(v, 8'h5A, "R4", "L pins");
    rd(4'hA, v); check(v, 8'h0A, "R4", "C pins");
    rd(4'h6, v); check(v, 8'hC3, "R5", "G pins incl input-only");
  endtask

  task automatic t_g_input_only;
    logic [7:0] v;
    wr(4'h5, 8'hFF);
    rd(4'h5, v); check(v, 8'h3F, "R5", "G dir readback");
    check(g_oe, 8'h3F, "R5", "G oe");
  endtask

  task automatic t_c_narrow;
    logic [7:0] v;
    wr(4'h8, 8'hFF);
    rd(4'h8, v); check(v, 8'h0F, "R6", "C val upper bits");
    wr(4'h9, 8'hF0);
    rd(4'h9, v); check(v, 8'h00, "R6", "C dir upper bits");
    check({4'b0, c_oe}, 8'h00, "R6", "C oe after upper write");
  endtask

  task automatic t_d_port;
    logic [7:0] v;
    wr(4'hC, 8'h12);
    check(d_out, 8'h12, "R7", "D out after write");
    rd(4'hC, v); check(v, 8'h12, "R7", "D readback");
  endtask

  task automatic t_halt;
    logic [7:0] v;
    wr(4'h4, 8'h81);
    check({7'b0, halt_req}, 8'h01, "R8", "halt set");
    repeat (3) @(negedge clk);
    check({7'b0, halt_req}, 8'h01, "R8", "halt held");
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    check({7'b0, halt_req}, 8'h00, "R8", "halt cleared by wake");
    rd(4'h4, v); check(v, 8'h01, "R8", "wake keeps other bits");
  endtask

  task automatic t_collision;
    logic [7:0] v;
    @(negedge clk);
    addr = 4'h4; wdata = 8'h80; we = 1'b1; wake = 1'b1;
    @(negedge clk);
    we = 1'b0; wake = 1'b0;
    check({7'b0, halt_req}, 8'h01, "R9", "write wins over wake");
    rd(4'h4, v); check(v, 8'h80, "R9", "G val after collision");
    @(negedge clk);
    addr = 4'h4; wdata = 8'h02; we = 1'b1; wake = 1'b1;
    @(negedge clk);
    we = 1'b0; wake = 1'b0;
    rd(4'h4, v); check(v, 8'h02, "R9", "write clear with wake");
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(4'h3, 8'hFF); wr(4'hB, 8'hFF); wr(4'hE, 8'hFF);
    rd(4'h3, v); check(v, 8'h00, "R10", "read 0x3");
    rd(4'hD, v); check(v, 8'h00, "R10", "read 0xD");
    rd(4'h0, v); check(v, 8'h3C, "R10", "L val untouched");
    check(l_oe, 8'h0F, "R10", "L oe untouched");
    check(d_out, 8'h12, "R10", "D untouched");
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(d_out, 8'hFF, "R7", "D ones during reset");
    check(l_oe, 8'h00, "R1", "L oe during reset");
    check({7'b0, halt_req}, 8'h00, "R1", "halt during reset");
    @(negedge clk);
    check(d_out, 8'hFF, "R7", "D ones held in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(d_out, 8'hFF, "R7", "D ones after release");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_readback();
    t_pins();
    t_g_input_only();
    t_c_narrow();
    t_d_port();
    t_halt();
    t_collision();
    t_unmapped();
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule